// File: doc/BRIEF.md
# Control Endpoint Transmit Buffer and Responder

This block sits between a CPU write port and a USB serializer for one control endpoint. The CPU opens a packet image and then writes it byte by byte. The image holds the sync byte, the PID, the payload and, unless the hardware CRC is requested, two CRC bytes. A byte of FFh closes the image and is not stored. From then on the block holds a "data ready" state.

The USB receive side presents decoded tokens with their kind, address and endpoint. For a matching token, the block hands the stored image to the serializer, or it asks for a handshake PID when nothing is stored. An IN token is answered at once. OUT and SETUP tokens are answered only after the receive side signals that the host's data phase has ended. The serializer pulls bytes one at a time. Once the last byte has been pulled, the buffer empties and stays empty until a new image is written.

Top module: `ep_tx_responder`

## Requirements
- R1: After reset, data_rdy_o, ovf_o, tx_start_o and hs_valid_o are 0 and tx_len_o is 0.
- R2: After open_i, each byte on wr_valid_i other than FFh is stored in order. tx_len_o counts the stored bytes. An FFh byte ends the image without being stored and sets data_rdy_o. Bytes written when no image is open are ignored.
- R3: A non-zero crc_cnt_i at open_i selects hardware CRC. The capacity is then 10 bytes, and 12 bytes otherwise. Bytes beyond the capacity are dropped and set ovf_o, which stays set until the next open_i.
- R4: A matching IN token (tok_kind_i = 0) with data ready raises tx_start_o for one cycle, in the cycle after the token. tx_data_o shows stored byte 0, and each tx_rd_i pulse advances it to the next byte.
- R5: A matching OUT (1) or SETUP (2) token with data ready raises tx_start_o in the cycle after data_done_i, and not before.
- R6: With no data ready, a matching IN token, or a matching OUT token followed by data_done_i, gives hs_valid_o with hs_pid_o = 4'hA (NAK) one cycle later.
- R7: With no data ready, a matching SETUP token followed by data_done_i gives hs_valid_o with hs_pid_o = 4'h2 (ACK).
- R8: The cycle after the tx_rd_i that takes the last stored byte, data_rdy_o is 0 and tx_len_o is 0. A following matching IN token gets a NAK.
- R9: A token whose address differs from dev_addr_i, whose endpoint differs from EP_NUM, or whose kind is 3 gives no response. The stored image stays ready.
- R10: tx_crc_cnt_o shows the crc_cnt_i value captured at open_i while the image is held.
- R11: An image closed by FFh with no stored bytes leaves data_rdy_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_addr_i | input | 7 | Device address that tokens must carry |
| open_i | input | 1 | Start a new packet image |
| crc_cnt_i | input | 4 | Payload byte count for hardware CRC; 0 means the image carries its own CRC |
| wr_valid_i | input | 1 | Write strobe for wr_data_i |
| wr_data_i | input | 8 | Image byte; FFh closes the image |
| ovf_o | output | 1 | Capacity exceeded during the current image |
| data_rdy_o | output | 1 | A complete image is held |
| tok_valid_i | input | 1 | Token strobe from the receive side |
| tok_kind_i | input | 2 | 0 IN, 1 OUT, 2 SETUP, 3 ignored |
| tok_addr_i | input | 7 | Token address |
| tok_ep_i | input | 4 | Token endpoint |
| data_done_i | input | 1 | Host data phase after OUT/SETUP has ended |
| tx_start_o | output | 1 | One-cycle pulse: serializer may send the image |
| tx_len_o | output | 4 | Number of stored bytes |
| tx_crc_cnt_o | output | 4 | Captured hardware CRC byte count |
| tx_data_o | output | 8 | Current byte for the serializer |
| tx_rd_i | input | 1 | Serializer has taken tx_data_o |
| hs_valid_o | output | 1 | One-cycle pulse: send a handshake |
| hs_pid_o | output | 4 | Handshake PID, ACK 4'h2 or NAK 4'hA |

## Verification
Random images of random length are loaded in both CRC modes. Each is followed by a random token kind, with mismatched address or endpoint mixed in. This tells a launch on IN apart from a launch deferred to the data phase, and shows that foreign tokens leave the image untouched. Tokens arriving at an empty buffer separate the SETUP-with-ACK case from the NAK cases. Directed images of exactly and just beyond capacity, plus an image holding only the terminator, probe the overflow flag and the empty case. Every draining pass compares each byte and then checks that the buffer has emptied.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
  typedef enum logic [1:0] {
    TOK_IN    = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WAIT = 2'd1,
    CS_SEND = 2'd2
  } ctrl_state_e;

  localparam logic [3:0] PID_ACK = 4'b0010;
  localparam logic [3:0] PID_NAK = 4'b1010;
  localparam logic [7:0] STOP_BYTE = 8'hFF;
endpackage

// File: rtl/ep_tx_match.sv
module ep_tx_match #(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int EP_NUM = 0
) (
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_kind_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              hit_o
);
  import ep_tx_pkg::*;

  localparam logic [EP_W-1:0] EP_ID = EP_W'(EP_NUM);

  logic addr_ok, ep_ok, kind_ok;

  assign addr_ok = (tok_addr_i == dev_addr_i);
  assign ep_ok   = (tok_ep_i == EP_ID);
  assign kind_ok = (tok_kind_e'(tok_kind_i) != TOK_RSVD);
  assign hit_o   = tok_valid_i && addr_ok && ep_ok && kind_ok;
endmodule

// File: rtl/ep_tx_store.sv
module ep_tx_store #(
  parameter int DEPTH     = 12,
  parameter int CRC_BYTES = 2,
  parameter int CNT_W     = $clog2(DEPTH + 1),
  parameter int PTR_W     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic [3:0]       crc_cnt_i,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  input  logic             launch_i,
  input  logic             rd_i,
  output logic             ready_o,
  output logic             sending_o,
  output logic [CNT_W-1:0] len_o,
  output logic [3:0]       crc_cnt_o,
  output logic             ovf_o,
  output logic [7:0]       rd_data_o
);
  import ep_tx_pkg::*;

  localparam logic [CNT_W-1:0] CAP_SW = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_HW = CNT_W'(DEPTH - CRC_BYTES);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] len_q, rd_ptr_q, cap;
  logic [3:0]       crc_q;
  logic             fill_q, ready_q, send_q, ovf_q;
  logic             open_ok, wr_seen, wr_stop, wr_take, wr_drop, pop, last_pop;

  assign cap      = (crc_q != 4'd0) ? CAP_HW : CAP_SW;
  assign open_ok  = open_i && !send_q;
  assign wr_seen  = !open_ok && wr_valid_i && fill_q;
  assign wr_stop  = wr_seen && (wr_data_i == STOP_BYTE);
  assign wr_take  = wr_seen && !wr_stop && (len_q < cap);
  assign wr_drop  = wr_seen && !wr_stop && !(len_q < cap);
  assign pop      = send_q && rd_i;
  assign last_pop = pop && (rd_ptr_q == len_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q   <= 1'b0;
      ready_q  <= 1'b0;
      send_q   <= 1'b0;
      ovf_q    <= 1'b0;
      len_q    <= '0;
      rd_ptr_q <= '0;
      crc_q    <= '0;
    end else begin
      if (open_ok) begin
        fill_q  <= 1'b1;
        ready_q <= 1'b0;
        ovf_q   <= 1'b0;
        len_q   <= '0;
        crc_q   <= crc_cnt_i;
      end else if (wr_stop) begin
        fill_q  <= 1'b0;
        ready_q <= (len_q != '0);
      end else if (wr_take) begin
        len_q <= len_q + CNT_W'(1);
      end else if (wr_drop) begin
        ovf_q <= 1'b1;
      end

      if (launch_i) begin
        send_q   <= 1'b1;
        rd_ptr_q <= '0;
      end else if (last_pop) begin
        send_q   <= 1'b0;
        ready_q  <= 1'b0;
        len_q    <= '0;
        rd_ptr_q <= '0;
      end else if (pop) begin
        rd_ptr_q <= rd_ptr_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_take) mem[len_q[PTR_W-1:0]] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_ptr_q[PTR_W-1:0]];
  assign ready_o   = ready_q;
  assign sending_o = send_q;
  assign len_o     = len_q;
  assign crc_cnt_o = crc_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/ep_tx_ctrl.sv
module ep_tx_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tok_hit_i,
  input  logic [1:0] tok_kind_i,
  input  logic       data_done_i,
  input  logic       ready_i,
  input  logic       sending_i,
  output logic       launch_o,
  output logic       tx_start_o,
  output logic       hs_valid_o,
  output logic [3:0] hs_pid_o
);
  import ep_tx_pkg::*;

  ctrl_state_e st_q, st_d;
  tok_kind_e   kind_q, kind_d, kind_in;
  logic        launch_d, hs_d, start_q, hs_q;
  logic [3:0]  pid_d, pid_q;

  assign kind_in = tok_kind_e'(tok_kind_i);

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    launch_d = 1'b0;
    hs_d     = 1'b0;
    pid_d    = PID_NAK;
    unique case (st_q)
      CS_IDLE: begin
        if (tok_hit_i) begin
          if (kind_in == TOK_IN) begin
            if (ready_i) begin
              launch_d = 1'b1;
              st_d     = CS_SEND;
            end else begin
              hs_d = 1'b1;
            end
          end else begin
            kind_d = kind_in;
            st_d   = CS_WAIT;
          end
        end
      end
      CS_WAIT: begin
        if (data_done_i) begin
          if (ready_i) begin
            launch_d = 1'b1;
            st_d     = CS_SEND;
          end else begin
            hs_d  = 1'b1;
            pid_d = (kind_q == TOK_SETUP) ? PID_ACK : PID_NAK;
            st_d  = CS_IDLE;
          end
        end
      end
      CS_SEND: begin
        if (!sending_i) st_d = CS_IDLE;
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= CS_IDLE;
      kind_q  <= TOK_IN;
      start_q <= 1'b0;
      hs_q    <= 1'b0;
      pid_q   <= PID_NAK;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      start_q <= launch_d;
      hs_q    <= hs_d;
      if (hs_d) pid_q <= pid_d;
    end
  end

  assign launch_o   = launch_d;
  assign tx_start_o = start_q;
  assign hs_valid_o = hs_q;
  assign hs_pid_o   = pid_q;
endmodule

// File: rtl/ep_tx_responder.sv
module ep_tx_responder #(
  parameter int DEPTH     = 12,
  parameter int CRC_BYTES = 2,
  parameter int ADDR_W    = 7,
  parameter int EP_W      = 4,
  parameter int EP_NUM    = 0,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              open_i,
  input  logic [3:0]        crc_cnt_i,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_data_i,
  output logic              ovf_o,
  output logic              data_rdy_o,
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_kind_i,
  input  logic [ADDR_W-1:0] tok_addr_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              data_done_i,
  output logic              tx_start_o,
  output logic [CNT_W-1:0]  tx_len_o,
  output logic [3:0]        tx_crc_cnt_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_rd_i,
  output logic              hs_valid_o,
  output logic [3:0]        hs_pid_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic tok_hit, launch, ready, sending;

  ep_tx_match #(
    .ADDR_W (ADDR_W),
    .EP_W   (EP_W),
    .EP_NUM (EP_NUM)
  ) u_match (
    .tok_valid_i (tok_valid_i),
    .tok_kind_i  (tok_kind_i),
    .tok_addr_i  (tok_addr_i),
    .tok_ep_i    (tok_ep_i),
    .dev_addr_i  (dev_addr_i),
    .hit_o       (tok_hit)
  );

  ep_tx_store #(
    .DEPTH     (DEPTH),
    .CRC_BYTES (CRC_BYTES),
    .CNT_W     (CNT_W),
    .PTR_W     (PTR_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (open_i),
    .crc_cnt_i  (crc_cnt_i),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .launch_i   (launch),
    .rd_i       (tx_rd_i),
    .ready_o    (ready),
    .sending_o  (sending),
    .len_o      (tx_len_o),
    .crc_cnt_o  (tx_crc_cnt_o),
    .ovf_o      (ovf_o),
    .rd_data_o  (tx_data_o)
  );

  ep_tx_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tok_hit_i   (tok_hit),
    .tok_kind_i  (tok_kind_i),
    .data_done_i (data_done_i),
    .ready_i     (ready),
    .sending_i   (sending),
    .launch_o    (launch),
    .tx_start_o  (tx_start_o),
    .hs_valid_o  (hs_valid_o),
    .hs_pid_o    (hs_pid_o)
  );

  assign data_rdy_o = ready;
endmodule

// File: rtl/ep_tx_responder_chk.sv
module ep_tx_responder_chk #(
  parameter int DEPTH = 12,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             open_i,
  input logic             ovf_o,
  input logic             data_rdy_o,
  input logic             tx_start_o,
  input logic [CNT_W-1:0] tx_len_o,
  input logic             hs_valid_o,
  input logic [3:0]       hs_pid_o
);
  // R6 R7
  resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> !tx_start_o);

  // R4
  start_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> (data_rdy_o && tx_len_o != '0));

  // R4
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  // R3
  len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_len_o <= CNT_W'(DEPTH));

  // R3
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !open_i) |=> ovf_o);

  // R6 R7
  hs_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_valid_o |-> (hs_pid_o == 4'h2 || hs_pid_o == 4'hA));
endmodule

bind ep_tx_responder ep_tx_responder_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .open_i     (open_i),
  .ovf_o      (ovf_o),
  .data_rdy_o (data_rdy_o),
  .tx_start_o (tx_start_o),
  .tx_len_o   (tx_len_o),
  .hs_valid_o (hs_valid_o),
  .hs_pid_o   (hs_pid_o)
);

// File: tb/ep_tx_responder_test.sv
module ep_tx_responder_test;
  localparam logic [6:0] DEV = 7'h15;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [6:0] dev_addr_i = DEV;
  logic       open_i = 0, wr_valid_i = 0, tok_valid_i = 0, data_done_i = 0, tx_rd_i = 0;
  logic [3:0] crc_cnt_i = 0, tok_ep_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [1:0] tok_kind_i = 0;
  logic [6:0] tok_addr_i = DEV;
  logic       ovf_o, data_rdy_o, tx_start_o, hs_valid_o;
  logic [3:0] tx_len_o, tx_crc_cnt_o, hs_pid_o;
  logic [7:0] tx_data_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] img [16];

  ep_tx_responder uut (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int cap_of(input int crc);
    return (crc != 0) ? 10 : 12;
  endfunction

  function automatic int exp_pid(input int kind);
    return (kind == 2) ? 4'h2 : 4'hA;
  endfunction

  // writes n bytes from img[] then the stop byte
  task automatic load(input int n, input int crc);
    @(negedge clk_i);
    open_i = 1; crc_cnt_i = 4'(crc);
    @(negedge clk_i);
    open_i = 0;
    for (int i = 0; i < n; i++) begin
      wr_valid_i = 1; wr_data_i = img[i];
      @(negedge clk_i);
    end
    wr_valid_i = 1; wr_data_i = 8'hFF;
    @(negedge clk_i);
    wr_valid_i = 0; wr_data_i = 8'h00;
  endtask

  task automatic token(input int kind, input logic [6:0] addr, input logic [3:0] ep);
    tok_valid_i = 1; tok_kind_i = 2'(kind); tok_addr_i = addr; tok_ep_i = ep;
    @(negedge clk_i);
    tok_valid_i = 0;
  endtask

  task automatic data_phase();
    data_done_i = 1;
    @(negedge clk_i);
    data_done_i = 0;
  endtask

  // matching token with full response check
  task automatic exchange(input int kind, input bit full, input int n);
    token(kind, DEV, 4'd0);
    if (kind != 0) begin
      chk(!tx_start_o && !hs_valid_o, "R5", "no reply before data phase", tx_start_o, 0);
      data_phase();
    end
    if (full) begin
      chk(tx_start_o === 1'b1, (kind == 0) ? "R4" : "R5", "tx_start", tx_start_o, 1);
      chk(!hs_valid_o, "R4", "no handshake with data", hs_valid_o, 0);
      for (int i = 0; i < n; i++) begin
        chk(tx_data_o === img[i], "R4", $sformatf("byte %0d", i), tx_data_o, img[i]);
        tx_rd_i = 1;
        @(negedge clk_i);
        tx_rd_i = 0;
      end
      chk(!data_rdy_o && tx_len_o == 0, "R8", "empty after send", {data_rdy_o, tx_len_o}, 0);
    end else begin
      chk(hs_valid_o === 1'b1 && !tx_start_o, (kind == 2) ? "R7" : "R6", "handshake", hs_valid_o, 1);
      chk(hs_pid_o == 4'(exp_pid(kind)), (kind == 2) ? "R7" : "R6", "pid", hs_pid_o, exp_pid(kind));
    end
    @(negedge clk_i);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    chk(!data_rdy_o && !ovf_o && !tx_start_o && !hs_valid_o && tx_len_o == 0, "R1", "reset state",
        {data_rdy_o, ovf_o, tx_start_o, hs_valid_o, tx_len_o}, 0);

    // R2: writes with no open image are ignored
    wr_valid_i = 1; wr_data_i = 8'h33; @(negedge clk_i);
    wr_valid_i = 1; wr_data_i = 8'hFF; @(negedge clk_i);
    wr_valid_i = 0;
    chk(tx_len_o == 0 && !data_rdy_o, "R2", "write without open", tx_len_o, 0);

    // R6, R7 on empty buffer
    exchange(0, 0, 0);
    exchange(1, 0, 0);
    exchange(2, 0, 0);

    // R11: terminator only
    load(0, 0);
    chk(!data_rdy_o && tx_len_o == 0, "R11", "empty image", data_rdy_o, 0);

    // R3: exact capacity, no overflow
    for (int i = 0; i < 14; i++) img[i] = 8'(i * 17 + 3);
    load(12, 0);
    chk(tx_len_o == 12 && !ovf_o && data_rdy_o, "R3", "full software-CRC image", tx_len_o, 12);
    exchange(0, 1, 12);
    // R3: beyond capacity
    load(14, 0);
    chk(tx_len_o == 12 && ovf_o, "R3", "overflow no hw crc", {ovf_o, tx_len_o}, {1'b1, 4'd12});
    exchange(0, 1, 12);
    load(11, 5);
    chk(tx_len_o == 10 && ovf_o, "R3", "overflow hw crc", {ovf_o, tx_len_o}, {1'b1, 4'd10});
    chk(tx_crc_cnt_o == 5, "R10", "crc count", tx_crc_cnt_o, 5);
    exchange(2, 1, 10);
    load(3, 0);
    chk(!ovf_o, "R3", "overflow cleared by open", ovf_o, 0);
    chk(tx_crc_cnt_o == 0, "R10", "crc count zero", tx_crc_cnt_o, 0);
    // R9: reserved kind ignored
    token(3, DEV, 4'd0);
    chk(!tx_start_o && !hs_valid_o && data_rdy_o, "R9", "reserved kind", tx_start_o, 0);
    exchange(1, 1, 3);
    // R8: next IN after drain gets NAK
    exchange(0, 0, 0);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int crc, n, kind;
      crc  = ($urandom % 2) ? int'($urandom % 8) + 1 : 0;
      n    = int'($urandom % cap_of(crc)) + 1;
      kind = int'($urandom % 3);
      for (int i = 0; i < n; i++) img[i] = 8'($urandom % 255);
      load(n, crc);
      chk(data_rdy_o && tx_len_o == 4'(n), "R2", "stored length", tx_len_o, n);
      chk(tx_crc_cnt_o == 4'(crc), "R10", "crc count", tx_crc_cnt_o, crc);
      if ($urandom % 3 == 0) begin
        if ($urandom % 2) token(kind, DEV ^ 7'h01, 4'd0);
        else token(kind, DEV, 4'd3);
        if (kind != 0) data_phase();
        chk(!tx_start_o && !hs_valid_o, "R9", "foreign token", {tx_start_o, hs_valid_o}, 0);
        chk(data_rdy_o && tx_len_o == 4'(n), "R9", "image kept", tx_len_o, n);
      end
      exchange(kind, 1, n);
      if ($urandom % 4 == 0) exchange(int'($urandom % 3), 0, 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule